// File: doc/BRIEF.md
# BCD Calendar Timekeeping Core

This block keeps wall-clock time and date as individual 4-bit BCD digits: seconds, minutes and hours in 24-hour form, a day-of-week counter, day of month, month (counted from 01) and a multi-digit year. Each pulse on the one-second tick input advances the time. A carry moves up through the fields at one field per clock, so a full year rollover takes several cycles. A busy output marks every cycle in which the digits may be inconsistent. A reader samples the outputs only while busy is low.

Software freezes the counters with the stop input and then rewrites any digit through a small parallel load port: a field selector plus a 4-bit data nibble. Ticks that arrive while stopped are dropped, not remembered. Month lengths follow the calendar. February gets a 29th day in any year whose last two digits divide by four.

Top module: `bcd_clock_core`

## Requirements
- R1: After reset the time reads year 2000, month 01, day 01, 00:00:00, day-of-week 0, and busy is low.
- R2: Seconds and minutes count 00 to 59 and wrap to 00 with a carry into the next field; hours count 00 to 23 and wrap to 00 with a carry into the day.
- R3: The day of month wraps to 01 and carries into the month after day 30 in months 04, 06, 09 and 11, after day 31 in the other months, and after day 28 or 29 in month 02.
- R4: Month 02 has 29 days exactly when the value of the two low year digits is a multiple of four (so 1900, 2000 and 2024 are leap years and 2023 is not).
- R5: Month 12 wraps to 01 and carries into the year. The year is a BCD count whose digits roll from all nines to all zeros.
- R6: The day-of-week nibble advances once each time the day of month advances, and wraps from 6 back to 0.
- R7: While stop is high a tick has no effect, and it is not applied later when stop falls.
- R8: With stop high and busy low, a pulse on load_i writes load_data_i into the digit picked by load_sel_i: 0 day-of-week, 1 hour tens, 2 hour units, 3 minute tens, 4 minute units, 5 second tens, 6 second units, 7 month tens, 8 month units, 9 day tens, 10 day units, and 11 upward the year digits from units (11) to thousands (14). The new digit shows on the outputs after the next clock edge.
- R9: A load pulse while stop is low changes nothing.
- R10: An accepted tick raises busy in its own cycle. The seconds field updates at that clock edge. Each further field reached by a carry adds one busy cycle. Busy therefore lasts 1 cycle for a plain second, 2 cycles for a minute carry and 6 cycles for a year carry.
- R11: A tick that is present while a carry is still rippling is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second advance pulse, one clock wide |
| stop_i | input | 1 | Freeze counting and enable loads |
| load_i | input | 1 | Write strobe for the load port |
| load_sel_i | input | SEL_W (4) | Digit selector for a load |
| load_data_i | input | 4 | BCD nibble to load |
| busy_o | output | 1 | Digits are being updated; outputs are not coherent |
| sec_o | output | 8 | Seconds, tens nibble over units nibble |
| min_o | output | 8 | Minutes, tens over units |
| hour_o | output | 8 | Hours (00-23), tens over units |
| mday_o | output | 8 | Day of month, tens over units |
| mon_o | output | 8 | Month (01-12), tens over units |
| dow_o | output | 4 | Day-of-week counter |
| year_o | output | 4*YEAR_DIGITS (16) | Year digits, most significant nibble first |

## Verification
The bench builds the core with its default parameters: four year digits and a last day-of-week value of 6. With these values, the 9999-to-0000 year wrap, the 1900 leap case under the divisible-by-four rule and the 6-to-0 weekday wrap are all reached with a few loads and a single tick. The six-stage carry from the last second of a year to the first of the next can therefore be timed cycle by cycle, together with the shorter carries at minute, hour, day and month boundaries.

// File: rtl/bcd_clock_pkg.sv
package bcd_clock_pkg;

    typedef logic [3:0] nib_t;
    typedef logic [7:0] pair_t;

    // Field being advanced by the carry ripple; IDLE means no carry pending
    typedef enum logic [2:0] {
        STG_IDLE,
        STG_MIN,
        STG_HOUR,
        STG_DAY,
        STG_MON,
        STG_YEAR
    } stage_e;

    // Load selector codes for the fixed fields; year digits follow them
    localparam int unsigned SEL_DOW      = 0;
    localparam int unsigned SEL_HOUR_T   = 1;
    localparam int unsigned SEL_HOUR_U   = 2;
    localparam int unsigned SEL_MIN_T    = 3;
    localparam int unsigned SEL_MIN_U    = 4;
    localparam int unsigned SEL_SEC_T    = 5;
    localparam int unsigned SEL_SEC_U    = 6;
    localparam int unsigned SEL_MON_T    = 7;
    localparam int unsigned SEL_MON_U    = 8;
    localparam int unsigned SEL_DAY_T    = 9;
    localparam int unsigned SEL_DAY_U    = 10;
    localparam int unsigned FIXED_FIELDS = 11;

    localparam pair_t SEC_LAST  = 8'h59;
    localparam pair_t HOUR_LAST = 8'h23;
    localparam pair_t MON_LAST  = 8'h12;

endpackage

// File: rtl/bcd_pair_step.sv
// Next value of a two-digit BCD field that counts FIRST..last and wraps.
module bcd_pair_step
    import bcd_clock_pkg::*;
#(
    parameter pair_t FIRST = 8'h00
) (
    input  pair_t cur_i,
    input  pair_t last_i,
    output pair_t nxt_o,
    output logic  wrap_o
);

    always_comb begin
        wrap_o = 1'b0;
        if (cur_i >= last_i) begin
            nxt_o  = FIRST;
            wrap_o = 1'b1;
        end else if (cur_i[3:0] >= 4'd9) begin
            nxt_o = {cur_i[7:4] + 4'd1, 4'd0};
        end else begin
            nxt_o = {cur_i[7:4], cur_i[3:0] + 4'd1};
        end
    end

endmodule

// File: rtl/bcd_month_len.sv
// Last day of the given month, with a divisible-by-four leap rule.
module bcd_month_len
    import bcd_clock_pkg::*;
(
    input  pair_t mon_i,
    input  nib_t  yr_units_i,
    input  nib_t  yr_tens_i,
    output pair_t last_day_o
);

    logic leap;

    always_comb begin
        // 10*t + u is a multiple of 4 when t even and u in {0,4,8},
        // or t odd and u in {2,6}
        if (yr_tens_i[0]) begin
            leap = (yr_units_i == 4'd2) || (yr_units_i == 4'd6);
        end else begin
            leap = (yr_units_i == 4'd0) || (yr_units_i == 4'd4) ||
                   (yr_units_i == 4'd8);
        end

        case (mon_i)
            8'h02:   last_day_o = leap ? 8'h29 : 8'h28;
            8'h04,
            8'h06,
            8'h09,
            8'h11:   last_day_o = 8'h30;
            default: last_day_o = 8'h31;
        endcase
    end

endmodule

// File: rtl/bcd_year_step.sv
// Increment of an N-digit BCD year, wrapping from all nines to zero.
module bcd_year_step #(
    parameter int unsigned DIGITS = 4,
    localparam int unsigned W     = 4 * DIGITS
) (
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] nxt_o
);

    logic [DIGITS:0] carry;

    assign carry[0] = 1'b1;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [3:0] d;
        assign d            = cur_i[g*4 +: 4];
        assign carry[g+1]   = carry[g] & (d >= 4'd9);
        assign nxt_o[g*4 +: 4] = !carry[g]  ? d    :
                                 (d >= 4'd9) ? 4'd0 : d + 4'd1;
    end

endmodule

// File: rtl/bcd_clock_core.sv
module bcd_clock_core
    import bcd_clock_pkg::*;
#(
    parameter int unsigned YEAR_DIGITS = 4,
    parameter int unsigned DOW_LAST    = 6,
    localparam int unsigned YEAR_W     = 4 * YEAR_DIGITS,
    localparam int unsigned SEL_W      = $clog2(FIXED_FIELDS + YEAR_DIGITS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              stop_i,
    input  logic              load_i,
    input  logic [SEL_W-1:0]  load_sel_i,
    input  logic [3:0]        load_data_i,
    output logic              busy_o,
    output logic [7:0]        sec_o,
    output logic [7:0]        min_o,
    output logic [7:0]        hour_o,
    output logic [7:0]        mday_o,
    output logic [7:0]        mon_o,
    output logic [3:0]        dow_o,
    output logic [YEAR_W-1:0] year_o
);

    localparam nib_t DOW_MAX = nib_t'(DOW_LAST);

    typedef struct packed {
        stage_e             stage;
        pair_t              sec;
        pair_t              min;
        pair_t              hour;
        pair_t              mday;
        pair_t              mon;
        nib_t               dow;
        logic [YEAR_W-1:0]  year;
    } clk_state_t;

    clk_state_t st_d, st_q;

    logic  ripple_active;
    logic  tick_ok;
    logic  load_ok;

    pair_t sec_nx,  min_nx,  hour_nx,  mday_nx,  mon_nx;
    logic  sec_wr,  min_wr,  hour_wr,  mday_wr,  mon_wr;
    pair_t mday_last;
    logic [YEAR_W-1:0] year_nx;
    nib_t  dow_nx;

    // ------------------------------------------------------------------
    // Per-field next-value logic
    // ------------------------------------------------------------------
    bcd_pair_step #(.FIRST(8'h00)) u_sec_step (
        .cur_i  (st_q.sec),
        .last_i (SEC_LAST),
        .nxt_o  (sec_nx),
        .wrap_o (sec_wr)
    );

    bcd_pair_step #(.FIRST(8'h00)) u_min_step (
        .cur_i  (st_q.min),
        .last_i (SEC_LAST),
        .nxt_o  (min_nx),
        .wrap_o (min_wr)
    );

    bcd_pair_step #(.FIRST(8'h00)) u_hour_step (
        .cur_i  (st_q.hour),
        .last_i (HOUR_LAST),
        .nxt_o  (hour_nx),
        .wrap_o (hour_wr)
    );

    bcd_month_len u_month_len (
        .mon_i      (st_q.mon),
        .yr_units_i (st_q.year[3:0]),
        .yr_tens_i  (st_q.year[7:4]),
        .last_day_o (mday_last)
    );

    bcd_pair_step #(.FIRST(8'h01)) u_mday_step (
        .cur_i  (st_q.mday),
        .last_i (mday_last),
        .nxt_o  (mday_nx),
        .wrap_o (mday_wr)
    );

    bcd_pair_step #(.FIRST(8'h01)) u_mon_step (
        .cur_i  (st_q.mon),
        .last_i (MON_LAST),
        .nxt_o  (mon_nx),
        .wrap_o (mon_wr)
    );

    bcd_year_step #(.DIGITS(YEAR_DIGITS)) u_year_step (
        .cur_i (st_q.year),
        .nxt_o (year_nx)
    );

    assign dow_nx = (st_q.dow >= DOW_MAX) ? 4'd0 : st_q.dow + 4'd1;

    // ------------------------------------------------------------------
    // Control
    // ------------------------------------------------------------------
    assign ripple_active = (st_q.stage != STG_IDLE);
    assign tick_ok       = tick_i & ~stop_i & ~ripple_active;
    assign load_ok       = load_i &  stop_i & ~ripple_active;

    always_comb begin
        st_d = st_q;
        case (st_q.stage)
            STG_IDLE: begin
                if (tick_ok) begin
                    st_d.sec   = sec_nx;
                    st_d.stage = sec_wr ? STG_MIN : STG_IDLE;
                end else if (load_ok) begin
                    case (int'(load_sel_i))
                        SEL_DOW:    st_d.dow       = load_data_i;
                        SEL_HOUR_T: st_d.hour[7:4] = load_data_i;
                        SEL_HOUR_U: st_d.hour[3:0] = load_data_i;
                        SEL_MIN_T:  st_d.min[7:4]  = load_data_i;
                        SEL_MIN_U:  st_d.min[3:0]  = load_data_i;
                        SEL_SEC_T:  st_d.sec[7:4]  = load_data_i;
                        SEL_SEC_U:  st_d.sec[3:0]  = load_data_i;
                        SEL_MON_T:  st_d.mon[7:4]  = load_data_i;
                        SEL_MON_U:  st_d.mon[3:0]  = load_data_i;
                        SEL_DAY_T:  st_d.mday[7:4] = load_data_i;
                        SEL_DAY_U:  st_d.mday[3:0] = load_data_i;
                        default: begin
                            for (int k = 0; k < int'(YEAR_DIGITS); k++) begin
                                if (int'(load_sel_i) == int'(FIXED_FIELDS) + k) begin
                                    st_d.year[k*4 +: 4] = load_data_i;
                                end
                            end
                        end
                    endcase
                end
            end
            STG_MIN: begin
                st_d.min   = min_nx;
                st_d.stage = min_wr ? STG_HOUR : STG_IDLE;
            end
            STG_HOUR: begin
                st_d.hour  = hour_nx;
                st_d.stage = hour_wr ? STG_DAY : STG_IDLE;
            end
            STG_DAY: begin
                st_d.mday  = mday_nx;
                st_d.dow   = dow_nx;
                st_d.stage = mday_wr ? STG_MON : STG_IDLE;
            end
            STG_MON: begin
                st_d.mon   = mon_nx;
                st_d.stage = mon_wr ? STG_YEAR : STG_IDLE;
            end
            STG_YEAR: begin
                st_d.year  = year_nx;
                st_d.stage = STG_IDLE;
            end
            default: st_d.stage = STG_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.stage <= STG_IDLE;
            st_q.sec   <= 8'h00;
            st_q.min   <= 8'h00;
            st_q.hour  <= 8'h00;
            st_q.mday  <= 8'h01;
            st_q.mon   <= 8'h01;
            st_q.dow   <= 4'd0;
            st_q.year  <= YEAR_W'(16'h2000);
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = tick_ok | ripple_active;
    assign sec_o  = st_q.sec;
    assign min_o  = st_q.min;
    assign hour_o = st_q.hour;
    assign mday_o = st_q.mday;
    assign mon_o  = st_q.mon;
    assign dow_o  = st_q.dow;
    assign year_o = st_q.year;

endmodule

// File: rtl/bcd_clock_core_chk.sv
module bcd_clock_core_chk #(
    parameter int unsigned SNAP_W = 60
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tick_i,
    input logic              stop_i,
    input logic              load_i,
    input logic              busy_i,
    input logic              rip_i,
    input logic [7:0]        sec_i,
    input logic [SNAP_W-1:0] snap_i
);

    logic accept;
    assign accept = tick_i && !stop_i && !rip_i;

    // R2
    sec_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept && sec_i == 8'h59) |=> (sec_i == 8'h00 && rip_i));

    // R10
    busy_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept |-> busy_i);

    // R7
    stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_i && !rip_i && !load_i) |=> $stable(snap_i));

    // R9
    run_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!stop_i && !busy_i) |=> $stable(snap_i));

    // R11
    ripple_sec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rip_i |=> $stable(sec_i));

endmodule

bind bcd_clock_core bcd_clock_core_chk #(.SNAP_W(44 + 4 * YEAR_DIGITS)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .stop_i (stop_i),
    .load_i (load_i),
    .busy_i (busy_o),
    .rip_i  (ripple_active),
    .sec_i  (sec_o),
    .snap_i ({year_o, mon_o, mday_o, hour_o, min_o, sec_o, dow_o})
);

// File: tb/bcd_clock_core_tb.sv
module bcd_clock_core_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        stop = 1'b0;
    logic        load = 1'b0;
    logic [3:0]  sel = '0;
    logic [3:0]  data = '0;
    logic        busy;
    logic [7:0]  sec, min, hour, mday, mon;
    logic [3:0]  dow;
    logic [15:0] year;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_clock_core u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tick_i      (tick),
        .stop_i      (stop),
        .load_i      (load),
        .load_sel_i  (sel),
        .load_data_i (data),
        .busy_o      (busy),
        .sec_o       (sec),
        .min_o       (min),
        .hour_o      (hour),
        .mday_o      (mday),
        .mon_o       (mon),
        .dow_o       (dow),
        .year_o      (year)
    );

    function automatic logic [59:0] tv(input logic [15:0] y, input logic [7:0] mo,
                                       input logic [7:0] d, input logic [7:0] h,
                                       input logic [7:0] mi, input logic [7:0] s,
                                       input logic [3:0] w);
        return {y, mo, d, h, mi, s, w};
    endfunction

    function automatic logic [59:0] now_v();
        return {year, mon, mday, hour, min, sec, dow};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic load_nib(input int s, input logic [3:0] v);
        @(negedge clk);
        load = 1'b1;
        sel  = 4'(s);
        data = v;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic set_time(input logic [15:0] y, input logic [7:0] mo,
                            input logic [7:0] d, input logic [7:0] h,
                            input logic [7:0] mi, input logic [7:0] s,
                            input logic [3:0] w);
        @(negedge clk);
        stop = 1'b1;
        load_nib(0, w);
        load_nib(1, h[7:4]);  load_nib(2, h[3:0]);
        load_nib(3, mi[7:4]); load_nib(4, mi[3:0]);
        load_nib(5, s[7:4]);  load_nib(6, s[3:0]);
        load_nib(7, mo[7:4]); load_nib(8, mo[3:0]);
        load_nib(9, d[7:4]);  load_nib(10, d[3:0]);
        load_nib(11, y[3:0]); load_nib(12, y[7:4]);
        load_nib(13, y[11:8]); load_nib(14, y[15:12]);
        @(negedge clk);
        stop = 1'b0;
    endtask

    // One tick; returns number of cycles busy was seen high
    task automatic do_tick(output int cnt);
        @(negedge clk);
        tick = 1'b1;
        #1;
        cnt = busy ? 1 : 0;
        @(negedge clk);
        tick = 1'b0;
        #1;
        for (int i = 0; i < 20 && busy; i++) begin
            cnt++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic tick_case(input string req, input logic [59:0] start,
                             input logic [59:0] exp, input int exp_busy);
        int n;
        set_time(start[59:44], start[43:36], start[35:28], start[27:20],
                 start[19:12], start[11:4], start[3:0]);
        do_tick(n);
        chk(now_v() == exp, req, "time after tick", 64'(now_v()), 64'(exp));
        chk(n == exp_busy, "R10", "busy cycles", 64'(n), 64'(exp_busy));
    endtask

    task automatic t_reset();
        #1;
        chk(now_v() == tv(16'h2000, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 4'h0),
            "R1", "reset time", 64'(now_v()),
            64'(tv(16'h2000, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 4'h0)));
        chk(busy == 1'b0, "R1", "reset busy", 64'(busy), 64'd0);
    endtask

    task automatic t_load();
        logic [59:0] e;
        e = tv(16'h1987, 8'h06, 8'h15, 8'h13, 8'h45, 8'h27, 4'h3);
        set_time(16'h1987, 8'h06, 8'h15, 8'h13, 8'h45, 8'h27, 4'h3);
        #1;
        chk(now_v() == e, "R8", "load readback", 64'(now_v()), 64'(e));
        // R9: load while running is ignored
        load_nib(6, 4'h9);
        load_nib(14, 4'h5);
        #1;
        chk(now_v() == e, "R9", "load while running", 64'(now_v()), 64'(e));
    endtask

    task automatic t_counting();
        // R2 plain second, minute carry, hour carry
        tick_case("R2", tv(16'h1987, 8'h06, 8'h15, 8'h13, 8'h45, 8'h27, 4'h3),
                  tv(16'h1987, 8'h06, 8'h15, 8'h13, 8'h45, 8'h28, 4'h3), 1);
        tick_case("R2", tv(16'h1987, 8'h06, 8'h15, 8'h13, 8'h45, 8'h59, 4'h3),
                  tv(16'h1987, 8'h06, 8'h15, 8'h13, 8'h46, 8'h00, 4'h3), 2);
        tick_case("R2", tv(16'h1987, 8'h06, 8'h15, 8'h13, 8'h59, 8'h59, 4'h3),
                  tv(16'h1987, 8'h06, 8'h15, 8'h14, 8'h00, 8'h00, 4'h3), 3);
        tick_case("R2", tv(16'h1987, 8'h06, 8'h15, 8'h09, 8'h59, 8'h59, 4'h3),
                  tv(16'h1987, 8'h06, 8'h15, 8'h10, 8'h00, 8'h00, 4'h3), 3);
    endtask

    task automatic t_months();
        // R3 month lengths
        tick_case("R3", tv(16'h2023, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59, 4'h1),
                  tv(16'h2023, 8'h05, 8'h01, 8'h00, 8'h00, 8'h00, 4'h2), 5);
        tick_case("R3", tv(16'h2023, 8'h01, 8'h30, 8'h23, 8'h59, 8'h59, 4'h1),
                  tv(16'h2023, 8'h01, 8'h31, 8'h00, 8'h00, 8'h00, 4'h2), 4);
        tick_case("R3", tv(16'h2023, 8'h01, 8'h31, 8'h23, 8'h59, 8'h59, 4'h1),
                  tv(16'h2023, 8'h02, 8'h01, 8'h00, 8'h00, 8'h00, 4'h2), 5);
        tick_case("R3", tv(16'h2023, 8'h11, 8'h30, 8'h23, 8'h59, 8'h59, 4'h1),
                  tv(16'h2023, 8'h12, 8'h01, 8'h00, 8'h00, 8'h00, 4'h2), 5);
    endtask

    task automatic t_leap();
        // R4 divisible-by-four rule
        tick_case("R4", tv(16'h2023, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, 4'h2),
                  tv(16'h2023, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00, 4'h3), 5);
        tick_case("R4", tv(16'h2024, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, 4'h2),
                  tv(16'h2024, 8'h02, 8'h29, 8'h00, 8'h00, 8'h00, 4'h3), 4);
        tick_case("R4", tv(16'h2024, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59, 4'h3),
                  tv(16'h2024, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00, 4'h4), 5);
        tick_case("R4", tv(16'h1900, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, 4'h2),
                  tv(16'h1900, 8'h02, 8'h29, 8'h00, 8'h00, 8'h00, 4'h3), 4);
        tick_case("R4", tv(16'h2014, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, 4'h2),
                  tv(16'h2014, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00, 4'h3), 5);
    endtask

    task automatic t_years();
        // R5 year carry and full wrap, R10 longest ripple
        tick_case("R5", tv(16'h1999, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59, 4'h5),
                  tv(16'h2000, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 4'h6), 6);
        tick_case("R5", tv(16'h9999, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59, 4'h5),
                  tv(16'h0000, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 4'h6), 6);
    endtask

    task automatic t_dow();
        // R6 weekday wrap 6 -> 0
        tick_case("R6", tv(16'h2023, 8'h05, 8'h10, 8'h23, 8'h59, 8'h59, 4'h6),
                  tv(16'h2023, 8'h05, 8'h11, 8'h00, 8'h00, 8'h00, 4'h0), 4);
    endtask

    task automatic t_stop();
        logic [59:0] e;
        int n;
        e = tv(16'h2023, 8'h05, 8'h10, 8'h12, 8'h00, 8'h10, 4'h2);
        set_time(16'h2023, 8'h05, 8'h10, 8'h12, 8'h00, 8'h10, 4'h2);
        @(negedge clk);
        stop = 1'b1;
        tick = 1'b1;
        #1;
        chk(busy == 1'b0, "R7", "busy with stop", 64'(busy), 64'd0);
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
        stop = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        chk(now_v() == e, "R7", "tick while stopped", 64'(now_v()), 64'(e));
        do_tick(n);
        e = tv(16'h2023, 8'h05, 8'h10, 8'h12, 8'h00, 8'h11, 4'h2);
        chk(now_v() == e, "R7", "single advance after stop", 64'(now_v()), 64'(e));
    endtask

    task automatic t_tick_in_ripple();
        logic [59:0] e;
        set_time(16'h2023, 8'h05, 8'h10, 8'h00, 8'h00, 8'h59, 4'h2);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);       // carry now rippling, tick still high
        #1;
        chk(busy == 1'b1, "R11", "busy during ripple", 64'(busy), 64'd1);
        @(negedge clk);
        tick = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        e = tv(16'h2023, 8'h05, 8'h10, 8'h00, 8'h01, 8'h00, 4'h2);
        chk(now_v() == e, "R11", "tick in ripple dropped", 64'(now_v()), 64'(e));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_counting();
        t_months();
        t_leap();
        t_years();
        t_dow();
        t_stop();
        t_tick_in_ripple();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule